// File: doc/BRIEF.md
# Two-Byte Result Read Port

This block presents a 10-bit conversion result to a host that has only an 8-bit data bus. The host fetches the result with two consecutive read strobes: the first returns the eight most significant bits. The second returns the two least significant bits in the top two bus positions, with zeros below them. The bus is modelled as a data vector plus an output-enable. The output-enable stands in for the tri-state drivers that the block would control.

A strobe from the conversion sequencer loads a fresh result into a holding register and points the next read at the high byte. A read is active while chip-select and read-strobe are both low. The first clock of that window raises a one-cycle read-start pulse, which the sequencer uses to clear its end-of-conversion interrupt. A byte pointer changes only when a read completes. Reads made without a new result cycle through the same two bytes of the held value.

Top module: `byte_split_reader`

## Requirements
- R1: While reset is high and on the first cycle after it, the output-enable, the read-start pulse and the data bus are all zero, and the next read returns the high byte.
- R2: The output-enable is a register. It is high in the cycle after a clock edge that sampled chip-select low and read-strobe low, and low otherwise.
- R3: When the pointer selects the high byte, the bus carries result bits 9..2 on bus bits 7..0.
- R4: When the pointer selects the low byte, result bit 1 is on bus bit 7 and result bit 0 is on bus bit 6, and bus bits 5..0 are zero.
- R5: A rising read-strobe while chip-select is still low ends the read and toggles the pointer. Without a new result, successive reads alternate high, low, high, ... from the held value.
- R6: A new-result strobe loads the result and sets the pointer to the high byte. This holds mid-sequence and in the same cycle a read starts; in that case the read returns the new high byte.
- R7: The read-start output is high for exactly one cycle, the same cycle in which the output-enable first rises for a read.
- R8: The data bus holds one value for the whole time the output-enable stays high, and reads as zero while it is low.
- R9: Chip-select rising first ends the read. With the parameter ADV_ON_CS_END at its default of 0, this leaves the pointer unchanged, so the next read returns the same byte.
- R10: Read-strobe low with chip-select high raises neither the output-enable nor read-start, and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| result_i | input | 10 | Conversion result from the sequencer |
| new_result_i | input | 1 | One-cycle strobe: result_i is a fresh result |
| cs_n_i | input | 1 | Chip-select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| bus_data_o | output | 8 | Byte presented to the host |
| bus_oe_o | output | 1 | Output-enable of the bus drivers |
| read_start_o | output | 1 | One-cycle pulse at the start of a read |

## Verification
Five result values are each read three times in a row. All-ones and all-zeros show that the padding is zero. The alternating patterns 0x2AA and 0x155 expose any swap of neighbouring bits or any off-by-one in the split. 0x203 sets only the bits at the edges of each byte. The third read of each value separates a pointer that wraps back to the high byte from one that sticks. Directed cases then cover these situations: a new result arriving mid-sequence, a new result arriving on the same cycle as a read start, a read ended by chip-select, and a read strobe with chip-select high. Each of these leaves a different byte on the next read.

// File: rtl/byte_split_pkg.sv
package byte_split_pkg;

    localparam int RES_W  = 10;
    localparam int BUS_W  = 8;
    localparam int LOW_W  = RES_W - BUS_W;
    localparam int PAD_W  = BUS_W - LOW_W;

    typedef enum logic {
        SEL_HIGH = 1'b0,
        SEL_LOW  = 1'b1
    } byte_sel_e;

    typedef struct packed {
        logic             oe;
        logic [BUS_W-1:0] data;
    } bus_beat_t;

    function automatic logic [BUS_W-1:0] format_byte(
        input logic [RES_W-1:0] res,
        input byte_sel_e        sel
    );
        logic [BUS_W-1:0] b;
        b = '0;
        if (sel == SEL_HIGH) begin
            b = res[RES_W-1:LOW_W];
        end else begin
            for (int i = 0; i < LOW_W; i++) begin
                b[PAD_W + i] = res[i];
            end
        end
        return b;
    endfunction

endpackage

// File: rtl/byte_split_strobe.sv
module byte_split_strobe #(
    parameter bit ADV_ON_CS_END = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    output logic active,
    output logic start_p,
    output logic done_p
);
    logic act_q;

    always_comb begin
        active  = ~cs_n & ~rd_n;
        start_p = active & ~act_q;
        done_p  = act_q & ~active & (~cs_n | ADV_ON_CS_END);
    end

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= active;
    end
endmodule

// File: rtl/byte_split_pointer.sv
module byte_split_pointer
    import byte_split_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [RES_W-1:0] result,
    input  logic             load,
    input  logic             done_p,
    output logic [RES_W-1:0] hold_nx,
    output byte_sel_e        sel_nx
);
    logic [RES_W-1:0] hold_q;
    byte_sel_e        sel_q;

    always_comb begin
        hold_nx = hold_q;
        sel_nx  = sel_q;
        if (load) begin
            hold_nx = result;
            sel_nx  = SEL_HIGH;
        end else if (done_p) begin
            sel_nx  = (sel_q == SEL_HIGH) ? SEL_LOW : SEL_HIGH;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            sel_q  <= SEL_HIGH;
        end else begin
            hold_q <= hold_nx;
            sel_q  <= sel_nx;
        end
    end
endmodule

// File: rtl/byte_split_drive.sv
module byte_split_drive
    import byte_split_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             start_p,
    input  logic [RES_W-1:0] hold,
    input  byte_sel_e        sel,
    output bus_beat_t        beat,
    output logic             start_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat    <= '0;
            start_q <= 1'b0;
        end else begin
            beat.oe <= active;
            start_q <= start_p;
            if (start_p)      beat.data <= format_byte(hold, sel);
            else if (!active) beat.data <= '0;
        end
    end
endmodule

// File: rtl/byte_split_reader.sv
module byte_split_reader
    import byte_split_pkg::*;
#(
    parameter bit ADV_ON_CS_END = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RES_W-1:0] result_i,
    input  logic             new_result_i,
    input  logic             cs_n_i,
    input  logic             rd_n_i,
    output logic [BUS_W-1:0] bus_data_o,
    output logic             bus_oe_o,
    output logic             read_start_o
);
    logic             active, start_p, done_p;
    logic [RES_W-1:0] hold_nx;
    byte_sel_e        sel_nx;
    bus_beat_t        beat;

    byte_split_strobe #(.ADV_ON_CS_END(ADV_ON_CS_END)) u_strobe (
        .clk(clk), .rst(rst), .cs_n(cs_n_i), .rd_n(rd_n_i),
        .active(active), .start_p(start_p), .done_p(done_p)
    );

    byte_split_pointer u_ptr (
        .clk(clk), .rst(rst), .result(result_i), .load(new_result_i),
        .done_p(done_p), .hold_nx(hold_nx), .sel_nx(sel_nx)
    );

    byte_split_drive u_drive (
        .clk(clk), .rst(rst), .active(active), .start_p(start_p),
        .hold(hold_nx), .sel(sel_nx), .beat(beat), .start_q(read_start_o)
    );

    assign bus_data_o = beat.data;
    assign bus_oe_o   = beat.oe;
endmodule

// File: rtl/byte_split_reader_chk.sv
module byte_split_reader_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n_i,
    input logic       rd_n_i,
    input logic [7:0] bus_data_o,
    input logic       bus_oe_o,
    input logic       read_start_o
);
    assert_oe_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (bus_oe_o == $past(!cs_n_i && !rd_n_i)));

    assert_start_with_oe_R7: assert property (@(posedge clk) disable iff (rst)
        read_start_o |-> (bus_oe_o && !$past(bus_oe_o)));

    assert_start_single_R7: assert property (@(posedge clk) disable iff (rst)
        read_start_o |=> !read_start_o);

    assert_data_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_data_o));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_o |-> (bus_data_o == 8'h00));

    assert_no_start_cs_high_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cs_n_i)) |-> (!read_start_o && !bus_oe_o));
endmodule

bind byte_split_reader byte_split_reader_chk u_chk (
    .clk(clk), .rst(rst), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
    .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o), .read_start_o(read_start_o)
);

// File: tb/tb_byte_split_reader.sv
module tb_byte_split_reader;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] result_i = '0;
    logic       new_result_i = 1'b0;
    logic       cs_n_i = 1'b1;
    logic       rd_n_i = 1'b1;
    logic [7:0] bus_data_o;
    logic       bus_oe_o;
    logic       read_start_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    byte_split_reader dut (
        .clk(clk), .rst(rst), .result_i(result_i), .new_result_i(new_result_i),
        .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .bus_data_o(bus_data_o),
        .bus_oe_o(bus_oe_o), .read_start_o(read_start_o)
    );

    // {result, expected high byte, expected low byte}
    localparam int NV = 5;
    localparam logic [25:0] VEC [NV] = '{
        {10'h3FF, 8'hFF, 8'hC0},
        {10'h000, 8'h00, 8'h00},
        {10'h2AA, 8'hAA, 8'h80},
        {10'h155, 8'h55, 8'h40},
        {10'h203, 8'h80, 8'hC0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [9:0] v);
        @(negedge clk);
        result_i = v; new_result_i = 1'b1;
        @(negedge clk);
        new_result_i = 1'b0;
    endtask

    // Read one byte; cs_first ends the read by raising chip-select first.
    task automatic do_read(input logic [7:0] exp, input string req, input bit cs_first);
        @(negedge clk);
        cs_n_i = 1'b0; rd_n_i = 1'b0;
        @(negedge clk);
        check({req, " data"}, bus_data_o, exp);
        check("R2 oe up", bus_oe_o, 1'b1);
        check("R7 start pulse", read_start_o, 1'b1);
        @(negedge clk);
        check("R8 data held", bus_data_o, exp);
        check("R7 start single", read_start_o, 1'b0);
        if (cs_first) cs_n_i = 1'b1; else rd_n_i = 1'b1;
        @(negedge clk);
        check("R2 oe down", bus_oe_o, 1'b0);
        check("R8 idle zero", bus_data_o, 8'h00);
        cs_n_i = 1'b1; rd_n_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 oe", bus_oe_o, 1'b0);
        check("R1 start", read_start_o, 1'b0);
        check("R1 data", bus_data_o, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 oe after", bus_oe_o, 1'b0);

        for (int i = 0; i < NV; i++) begin
            load(VEC[i][25:16]);
            do_read(VEC[i][15:8], "R3 high", 1'b0);
            do_read(VEC[i][7:0],  "R4 low",  1'b0);
            do_read(VEC[i][15:8], "R5 wrap", 1'b0);
        end

        // R6: new result mid-sequence resets to high byte
        load(10'h2AA);
        do_read(8'hAA, "R6 pre", 1'b0);
        load(10'h155);
        do_read(8'h55, "R6 reset mid", 1'b0);

        // R6: new result in same cycle as read start
        do_read(8'h40, "R6 low pre", 1'b0);   // pointer back to low? no: after high read -> low
        @(negedge clk);
        result_i = 10'h203; new_result_i = 1'b1;
        cs_n_i = 1'b0; rd_n_i = 1'b0;
        @(negedge clk);
        new_result_i = 1'b0;
        check("R6 same cycle", bus_data_o, 8'h80);
        rd_n_i = 1'b1;
        @(negedge clk);
        cs_n_i = 1'b1;
        do_read(8'hC0, "R6 then low", 1'b0);

        // R9: read ended by chip-select leaves pointer
        load(10'h3FF);
        do_read(8'hFF, "R9 first", 1'b1);
        do_read(8'hFF, "R9 repeat", 1'b0);

        // R10: rd low with cs high
        @(negedge clk);
        rd_n_i = 1'b0;
        @(negedge clk);
        check("R10 oe", bus_oe_o, 1'b0);
        check("R10 start", read_start_o, 1'b0);
        rd_n_i = 1'b1;
        @(negedge clk);
        do_read(8'hC0, "R10 pointer kept", 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule